// File: doc/BRIEF.md
# DMA Address Hold Loop Generator

This block produces the byte address of every beat of one side of a DMA transfer. A start pulse loads a start address, a byte count and the hold settings. The block then presents one address per beat, one byte per beat. It advances each time the consumer accepts the current beat with a valid/ready handshake. It raises a last-beat flag on the final byte of the count.

With hold disabled, the address climbs by one per beat across the whole transfer. With hold enabled, the address stays inside a small window that starts at the start address. The window is 1, 2, 4 or 8 bytes, chosen by a 2-bit code holding the base-2 logarithm of its size. Beat k is then placed at the start address plus (k mod window). This suits a fixed peripheral register or a small FIFO aperture. The hold-enable bit and the code come from a mode register outside the block. A source-side instance and a destination-side instance are each wired to their own fields of that register.

Data movement, bus protocol and descriptor fetching are handled elsewhere.

Top module: `dma_hold_addr_gen`

## Requirements
- R1: While reset is high, and in the cycle after it, `beat_valid_o` and `beat_last_o` are low.
- R2: A start pulse with a nonzero count makes `beat_valid_o` high in the next cycle, with `beat_addr_o` equal to the loaded start address.
- R3: With hold disabled, each accepted beat that is not the final one moves the address to the previous address plus one, wrapping modulo 2^ADDR_W.
- R4: With hold enabled, beat k (counting from 0) carries the address start + (k mod W). The window base is the start address as given, with no alignment.
- R5: The window code maps 0 to W=1, 1 to W=2, 2 to W=4 and 3 to W=8 bytes.
- R6: While hold is disabled, the window code has no effect on the addresses.
- R7: `beat_last_o` is high on exactly the Nth beat of an N-byte transfer, whatever the position inside the window.
- R8: After the final beat is accepted, `beat_valid_o` is low from the next cycle until the next start pulse.
- R9: While a beat is offered and not accepted, the address, the last flag and the valid flag stay unchanged.
- R10: A start pulse during a sequence drops the remainder of the old sequence and loads the new one. The start pulse wins over a beat accepted in the same cycle.
- R11: A start pulse with a count of zero produces no beat.
- R12: The hold enable and window code are sampled only at the start pulse. Later changes on those inputs do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that loads a new sequence |
| start_addr_i | input | ADDR_W | First address and window base |
| byte_cnt_i | input | CNT_W | Number of bytes (beats) in the sequence |
| hold_en_i | input | 1 | Hold (windowed addressing) enable |
| hold_code_i | input | 2 | Window size as log2 of bytes |
| beat_ready_i | input | 1 | Consumer accepts the offered beat |
| beat_valid_o | output | 1 | A beat address is offered |
| beat_addr_o | output | ADDR_W | Address of the offered beat |
| beat_last_o | output | 1 | Offered beat is the final byte of the count |

## Verification
The assertions assume that `beat_ready_i` matters only while `beat_valid_o` is high. They also assume that start pulses last exactly one cycle and that the start inputs are stable around the clock edge. The stimulus drives every input at the falling clock edge and raises `start_i` for a single cycle at a time. Some restarts land on a stalled beat and some on an accepted one. The reference model in the bench follows every cycle, so mid-sequence changes of the hold inputs, address wrap at the top of the space and zero counts are all compared against expected behaviour.

// File: rtl/dma_hold_pkg.sv
package dma_hold_pkg;

  localparam int WIN_CODE_W   = 2;
  localparam int WIN_MAX_LOG2 = (1 << WIN_CODE_W) - 1;

  typedef struct packed {
    logic                  en;
    logic [WIN_CODE_W-1:0] code;
  } hold_cfg_t;

endpackage

// File: rtl/dma_hold_beat_track.sv
module dma_hold_beat_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             adv_i,
  output logic             valid_o,
  output logic             last_o,
  output logic [CNT_W-1:0] idx_next_o
);

  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] idx_q;
  logic             valid_q;
  logic             last_q;

  assign idx_next_o = idx_q + CNT_W'(1);
  assign valid_o    = valid_q;
  assign last_o     = last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      left_q  <= '0;
      idx_q   <= '0;
    end else if (load_i) begin
      valid_q <= |cnt_i;
      last_q  <= (cnt_i == CNT_W'(1));
      left_q  <= cnt_i;
      idx_q   <= '0;
    end else if (adv_i) begin
      if (last_q) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
        left_q  <= '0;
      end else begin
        idx_q  <= idx_next_o;
        left_q <= left_q - CNT_W'(1);
        last_q <= (left_q == CNT_W'(2));
      end
    end
  end

  // R7: the flag marks the beat with exactly one byte left
  a_r7_last_matches_left: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (last_q == (left_q == CNT_W'(1))));

  // R8: nothing follows the accepted final beat
  a_r8_stop_after_last: assert property (@(posedge clk) disable iff (rst)
    (valid_q && last_q && adv_i && !load_i) |=> !valid_q);

  // R11: an empty load offers no beat
  a_r11_empty_load: assert property (@(posedge clk) disable iff (rst)
    (load_i && (cnt_i == '0)) |=> !valid_q);

endmodule

// File: rtl/dma_hold_addr_calc.sv
module dma_hold_addr_calc
  import dma_hold_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  hold_cfg_t         cfg_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int PAD_W = ADDR_W - CNT_W;

  logic [CNT_W-1:0] win_mask;
  logic [CNT_W-1:0] offset;

  // mask bit k survives when hold is off, or when the window covers bit k
  for (genvar k = 0; k < CNT_W; k++) begin : g_mask
    if (k < WIN_MAX_LOG2) begin : g_win
      assign win_mask[k] = ~cfg_i.en | (cfg_i.code > WIN_CODE_W'(k));
    end else begin : g_lin
      assign win_mask[k] = ~cfg_i.en;
    end
  end

  assign offset = idx_i & win_mask;
  assign addr_o = base_i + {{PAD_W{1'b0}}, offset};

endmodule

// File: rtl/dma_hold_addr_gen.sv
module dma_hold_addr_gen
  import dma_hold_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [ADDR_W-1:0]     start_addr_i,
  input  logic [CNT_W-1:0]      byte_cnt_i,
  input  logic                  hold_en_i,
  input  logic [WIN_CODE_W-1:0] hold_code_i,
  input  logic                  beat_ready_i,
  output logic                  beat_valid_o,
  output logic [ADDR_W-1:0]     beat_addr_o,
  output logic                  beat_last_o
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_next;
  hold_cfg_t         cfg_q;
  logic [CNT_W-1:0]  idx_next;
  logic              adv;

  assign adv         = beat_valid_o && beat_ready_i;
  assign beat_addr_o = addr_q;

  dma_hold_beat_track #(.CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .load_i     (start_i),
    .cnt_i      (byte_cnt_i),
    .adv_i      (adv),
    .valid_o    (beat_valid_o),
    .last_o     (beat_last_o),
    .idx_next_o (idx_next)
  );

  dma_hold_addr_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_calc (
    .base_i (base_q),
    .idx_i  (idx_next),
    .cfg_i  (cfg_q),
    .addr_o (addr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      addr_q <= '0;
      cfg_q  <= '0;
    end else if (start_i) begin
      base_q <= start_addr_i;
      addr_q <= start_addr_i;
      cfg_q  <= '{en: hold_en_i, code: hold_code_i};
    end else if (adv && !beat_last_o) begin
      addr_q <= addr_next;
    end
  end

  // R1: idle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!beat_valid_o && !beat_last_o));

  // R2 and R10: a load presents the new start address at once
  a_r2_first_beat: assert property (@(posedge clk) disable iff (rst)
    (start_i && (byte_cnt_i != '0)) |=>
      (beat_valid_o && (beat_addr_o == $past(start_addr_i))));

  // R9: an unaccepted beat is held
  a_r9_stall_stable: assert property (@(posedge clk) disable iff (rst)
    (beat_valid_o && !beat_ready_i && !start_i) |=>
      (beat_valid_o && $stable(beat_addr_o) && $stable(beat_last_o)));

  // R3 and R6: linear step of one byte
  a_r3_linear_step: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.en && adv && !beat_last_o && !start_i) |=>
      (beat_addr_o == $past(beat_addr_o) + ADDR_W'(1)));

  // R4 and R5: held addresses never leave the window
  a_r4_in_window: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.en && beat_valid_o) |->
      ((beat_addr_o - base_q) < (ADDR_W'(1) << cfg_q.code)));

endmodule

// File: tb/dma_hold_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma_hold_addr_gen_tb_top;

  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic [CNT_W-1:0]  byte_cnt_i = '0;
  logic              hold_en_i = 1'b0;
  logic [1:0]        hold_code_i = '0;
  logic              beat_ready_i = 1'b0;
  logic              beat_valid_o;
  logic [ADDR_W-1:0] beat_addr_o;
  logic              beat_last_o;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    cyc    = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit          m_valid = 0;
  bit          m_last  = 0;
  logic [31:0] m_addr  = '0;
  logic [31:0] m_base  = '0;
  bit          m_en    = 0;
  int          m_win   = 1;
  int          m_left  = 0;
  int          m_idx   = 0;

  always #2.5 clk = ~clk;

  dma_hold_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .byte_cnt_i   (byte_cnt_i),
    .hold_en_i    (hold_en_i),
    .hold_code_i  (hold_code_i),
    .beat_ready_i (beat_ready_i),
    .beat_valid_o (beat_valid_o),
    .beat_addr_o  (beat_addr_o),
    .beat_last_o  (beat_last_o)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      m_valid = 0;
      m_last  = 0;
    end else if (start_i) begin
      m_base  = start_addr_i;
      m_addr  = start_addr_i;
      m_en    = hold_en_i;
      m_win   = 1 << hold_code_i;
      m_left  = int'(byte_cnt_i);
      m_idx   = 0;
      m_valid = (m_left != 0);
      m_last  = (m_left == 1);
    end else if (m_valid && beat_ready_i) begin
      if (m_last) begin
        m_valid = 0;
        m_last  = 0;
      end else begin
        m_idx  = m_idx + 1;
        m_left = m_left - 1;
        m_last = (m_left == 1);
        m_addr = m_en ? m_base + 32'(m_idx % m_win) : m_base + 32'(m_idx);
      end
    end
  end

  // compare with the model on every falling edge once out of reset
  always @(negedge clk) begin
    if (!rst) begin
      n_chk = n_chk + 1;
      if (beat_valid_o !== m_valid || beat_last_o !== m_last ||
          (m_valid && beat_addr_o !== m_addr)) begin
        n_fail = n_fail + 1;
        $display("FAIL %s cycle %0d: valid/last/addr got %0b/%0b/%h exp %0b/%0b/%h",
                 cur_req, cyc, beat_valid_o, beat_last_o, beat_addr_o,
                 m_valid, m_last, m_addr);
      end
    end
  end

  task automatic pulse_start(input logic [31:0] a, input int n,
                             input bit en, input int code);
    start_addr_i = a;
    byte_cnt_i   = CNT_W'(n);
    hold_en_i    = en;
    hold_code_i  = 2'(code);
    start_i      = 1'b1;
    @(negedge clk);
    start_i      = 1'b0;
  endtask

  task automatic drain(input bit stall);
    for (int i = 0; i < 400 && (m_valid || beat_valid_o); i++) begin
      beat_ready_i = stall ? ((cyc % 3) != 0) : 1'b1;
      @(negedge clk);
    end
    beat_ready_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_seq(input string req, input logic [31:0] a, input int n,
                         input bit en, input int code, input bit stall);
    cur_req = req;
    @(negedge clk);
    pulse_start(a, n, en, code);
    drain(stall);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state seen while reset is held
    n_chk = n_chk + 1;
    if (beat_valid_o !== 1'b0 || beat_last_o !== 1'b0) begin
      n_fail = n_fail + 1;
      $display("FAIL R1 reset: valid/last got %0b/%0b exp 0/0", beat_valid_o, beat_last_o);
    end
    rst = 1'b0;
    beat_ready_i = 1'b1;
    @(negedge clk);

    run_seq("R2 R3 linear",            32'h0000_1000, 6,  0, 0, 0);
    run_seq("R3 linear stalled R9",    32'h0000_2200, 9,  0, 0, 1);
    run_seq("R4 R5 window 4 R7",       32'h0000_2002, 10, 1, 2, 0);
    run_seq("R4 R5 window 8 R9",       32'h0000_3005, 19, 1, 3, 1);
    run_seq("R5 window 1",             32'h0000_4444, 5,  1, 0, 0);
    run_seq("R5 window 2 R7",          32'h0000_5001, 7,  1, 1, 1);
    run_seq("R6 code ignored",         32'h0000_6000, 5,  0, 3, 0);
    run_seq("R3 address wrap",         32'hFFFF_FFFE, 4,  0, 0, 0);
    run_seq("R7 single byte",          32'h0000_7000, 1,  1, 3, 0);
    run_seq("R11 zero count",          32'h0000_8000, 0,  1, 2, 0);

    // R8: idle time after the final beat, valid must stay low
    cur_req = "R8 idle after last";
    repeat (6) @(negedge clk);

    // R10: restart while beats are being accepted
    cur_req = "R10 restart on accept";
    pulse_start(32'h0000_9000, 20, 1, 3);
    repeat (5) @(negedge clk);
    pulse_start(32'h0000_A000, 3, 0, 0);
    drain(0);

    // R10: restart while a beat is stalled
    cur_req = "R10 restart on stall";
    pulse_start(32'h0000_B003, 12, 1, 1);
    beat_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    pulse_start(32'h0000_C000, 4, 1, 2);
    drain(1);

    // R12: hold inputs change while a sequence runs
    cur_req = "R12 settings frozen";
    pulse_start(32'h0000_D001, 12, 1, 2);
    hold_en_i   = 1'b0;
    hold_code_i = 2'd3;
    repeat (2) @(negedge clk);
    hold_en_i   = 1'b1;
    hold_code_i = 2'd0;
    drain(1);

    // R11: zero count restart abandons a running sequence
    cur_req = "R11 R10 zero restart";
    pulse_start(32'h0000_E000, 8, 0, 0);
    repeat (2) @(negedge clk);
    pulse_start(32'h0000_F000, 0, 0, 0);
    repeat (4) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk  = n_chk + 1;
    n_fail = n_fail + 1;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule